// File: doc/BRIEF.md
# Flow Record Updater with Forwarding Buffer

This block sits in the update loop of a per-flow statistics table. Each cycle it may receive one flow record that the table lookup returned (a flow key plus its stored value fields) together with the statistics of the packet that caused the lookup: its arrival timestamp and its length in bytes. It computes the new value fields and presents the updated record one cycle later for writing back into the table.

The table takes R cycles to read and W cycles to write, so a record read for one packet can be out of date when an earlier packet of the same flow is still in flight. To count back-to-back packets correctly without stalling, the block keeps its last R+W-1 results in a shift buffer. Each incoming record's key is compared against every buffer slot at once. When one or more slots match, the newest matching result replaces the stale copy from the table. A selector picks the base record, per-field units compute timestamps and counters, and a composer reassembles the result.

The value fields are a 64-bit first-seen timestamp, a 64-bit last-seen timestamp, a 24-bit packet counter and a 40-bit byte counter. The key is 104 bits wide and the packet length is 16 bits.

Top module: `fru_updater`

## Requirements
- R1: A record accepted with `in_valid` high appears on the outputs exactly one clock later with `out_valid` high and `out_key` equal to the input key; `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R2: The output last-seen timestamp equals the packet timestamp `in_ts` of the same transfer.
- R3: If the base record's packet counter is zero, the output first-seen timestamp is `in_ts`; otherwise it keeps the base record's first-seen timestamp.
- R4: The output packet counter is the base counter plus one, and stays at 2^24-1 when the base is already 2^24-1.
- R5: The output byte counter is the base byte counter plus `in_len`, clamped to 2^40-1 when the sum would exceed it.
- R6: If a result with the same key left the block in any of the previous D = RD_LAT+WR_LAT-1 cycles (3 by default), that result is the base record and the table value presented on the inputs is ignored.
- R7: A result with a different key, or one that left the block more than D cycles earlier, is never used as the base; the input record is used instead.
- R8: When several buffered results share the incoming key, the most recently produced one is the base.
- R9: Reset clears every buffer slot to empty and drives `out_valid` low; an empty slot never matches, including an all-zero key, so the first transfers after reset use the input record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record and packet statistics present this cycle |
| in_key | input | 104 | Flow key of the record |
| in_first_ts | input | 64 | Stored first-seen timestamp from the table |
| in_last_ts | input | 64 | Stored last-seen timestamp from the table |
| in_pkt_cnt | input | 24 | Stored packet counter from the table |
| in_byte_cnt | input | 40 | Stored byte counter from the table |
| in_ts | input | 64 | Arrival timestamp of the current packet |
| in_len | input | 16 | Length of the current packet in bytes |
| out_valid | output | 1 | Updated record present |
| out_key | output | 104 | Flow key of the updated record |
| out_first_ts | output | 64 | Updated first-seen timestamp |
| out_last_ts | output | 64 | Updated last-seen timestamp |
| out_pkt_cnt | output | 24 | Updated packet counter |
| out_byte_cnt | output | 40 | Updated byte counter |

## Verification
The bound checker watches, on every cycle, the one-cycle valid and key timing, that the last-seen timestamp tracks the packet, that a result whose counter is one carries matching first and last timestamps, and that counters never fall below the packet's own contribution. Which earlier result was chosen as the base cannot be seen from one cycle's ports, so forwarding across the exact D-cycle window, the refusal one cycle beyond it, newest-first choice among repeated keys, the clearing of the buffer by reset and both saturation edges are shown only by the bench's directed and random sequences, checked against a model that keeps its own history of results.

// File: rtl/fru_pkg.sv
package fru_pkg;

    parameter int KEY_W  = 104;
    parameter int TS_W   = 64;
    parameter int PKT_W  = 24;
    parameter int BYTE_W = 40;
    parameter int LEN_W  = 16;

    // Value part of a flow record
    typedef struct packed {
        logic [TS_W-1:0]   first_ts;
        logic [TS_W-1:0]   last_ts;
        logic [PKT_W-1:0]  pkt_cnt;
        logic [BYTE_W-1:0] byte_cnt;
    } flow_val_t;

    // Key plus value
    typedef struct packed {
        logic [KEY_W-1:0] key;
        flow_val_t        val;
    } flow_rec_t;

    // One forwarding buffer slot
    typedef struct packed {
        logic      vld;
        flow_rec_t rec;
    } fwd_slot_t;

    // Per-packet statistics
    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [LEN_W-1:0] len;
    } pkt_stat_t;

    function automatic logic key_eq(input logic [KEY_W-1:0] a,
                                    input logic [KEY_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/fru_fwd_buf.sv
module fru_fwd_buf
    import fru_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_vld,
    input  flow_rec_t        push_rec,
    input  logic [KEY_W-1:0] look_key,
    output logic             hit,
    output flow_val_t        hit_val
);

    fwd_slot_t        slot_q [DEPTH];
    logic [DEPTH-1:0] match;

    // Slot 0 is the newest result; every slot moves one place per cycle.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot_q[g] <= '0;
                    end else begin
                        slot_q[g].vld <= push_vld;
                        slot_q[g].rec <= push_rec;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot_q[g] <= '0;
                    end else begin
                        slot_q[g] <= slot_q[g-1];
                    end
                end
            end
            assign match[g] = slot_q[g].vld && key_eq(slot_q[g].rec.key, look_key);
        end
    endgenerate

    // Oldest first so that a newer match overrides an older one.
    always_comb begin
        hit     = 1'b0;
        hit_val = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_val = slot_q[i].rec.val;
            end
        end
    end

endmodule

// File: rtl/fru_sat_add.sv
module fru_sat_add #(
    parameter int W     = 24,
    parameter int INC_W = 1
) (
    input  logic [W-1:0]     base,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     sum
);

    logic [W:0] wide;

    assign wide = {1'b0, base} + (W+1)'(inc);
    assign sum  = wide[W] ? {W{1'b1}} : wide[W-1:0];

endmodule

// File: rtl/fru_ts_unit.sv
module fru_ts_unit
    import fru_pkg::*;
(
    input  logic [TS_W-1:0] base_first,
    input  logic            base_fresh,
    input  logic [TS_W-1:0] pkt_ts,
    output logic [TS_W-1:0] new_first,
    output logic [TS_W-1:0] new_last
);

    assign new_first = base_fresh ? pkt_ts : base_first;
    assign new_last  = pkt_ts;

endmodule

// File: rtl/fru_updater.sv
module fru_updater
    import fru_pkg::*;
#(
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [TS_W-1:0]   in_first_ts,
    input  logic [TS_W-1:0]   in_last_ts,
    input  logic [PKT_W-1:0]  in_pkt_cnt,
    input  logic [BYTE_W-1:0] in_byte_cnt,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    output logic [KEY_W-1:0]  out_key,
    output logic [TS_W-1:0]   out_first_ts,
    output logic [TS_W-1:0]   out_last_ts,
    output logic [PKT_W-1:0]  out_pkt_cnt,
    output logic [BYTE_W-1:0] out_byte_cnt
);

    localparam int FWD_DEPTH = RD_LAT + WR_LAT - 1;

    flow_val_t table_val;
    flow_val_t fwd_val;
    flow_val_t base_val;
    flow_rec_t new_rec;
    flow_rec_t res_q;
    pkt_stat_t stat;
    logic      fwd_hit;
    logic      res_vld_q;

    assign table_val = '{first_ts: in_first_ts, last_ts: in_last_ts,
                         pkt_cnt: in_pkt_cnt, byte_cnt: in_byte_cnt};
    assign stat      = '{ts: in_ts, len: in_len};

    fru_fwd_buf #(.DEPTH(FWD_DEPTH)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .push_vld (in_valid),
        .push_rec (new_rec),
        .look_key (in_key),
        .hit      (fwd_hit),
        .hit_val  (fwd_val)
    );

    // Selector
    assign base_val = fwd_hit ? fwd_val : table_val;

    // Field units
    fru_ts_unit u_ts (
        .base_first (base_val.first_ts),
        .base_fresh (base_val.pkt_cnt == '0),
        .pkt_ts     (stat.ts),
        .new_first  (new_rec.val.first_ts),
        .new_last   (new_rec.val.last_ts)
    );

    fru_sat_add #(.W(PKT_W), .INC_W(1)) u_pkt (
        .base (base_val.pkt_cnt),
        .inc  (1'b1),
        .sum  (new_rec.val.pkt_cnt)
    );

    fru_sat_add #(.W(BYTE_W), .INC_W(LEN_W)) u_byte (
        .base (base_val.byte_cnt),
        .inc  (stat.len),
        .sum  (new_rec.val.byte_cnt)
    );

    // Composer
    assign new_rec.key = in_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld_q <= 1'b0;
            res_q     <= '0;
        end else begin
            res_vld_q <= in_valid;
            if (in_valid) begin
                res_q <= new_rec;
            end
        end
    end

    assign out_valid    = res_vld_q;
    assign out_key      = res_q.key;
    assign out_first_ts = res_q.val.first_ts;
    assign out_last_ts  = res_q.val.last_ts;
    assign out_pkt_cnt  = res_q.val.pkt_cnt;
    assign out_byte_cnt = res_q.val.byte_cnt;

endmodule

// File: rtl/fru_updater_chk.sv
module fru_updater_chk
    import fru_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [KEY_W-1:0]  in_key,
    input logic [TS_W-1:0]   in_ts,
    input logic [LEN_W-1:0]  in_len,
    input logic              out_valid,
    input logic [KEY_W-1:0]  out_key,
    input logic [TS_W-1:0]   out_first_ts,
    input logic [TS_W-1:0]   out_last_ts,
    input logic [PKT_W-1:0]  out_pkt_cnt,
    input logic [BYTE_W-1:0] out_byte_cnt
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid)); // R1

    AST_KEY_CARRIED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_key == $past(in_key)); // R1

    AST_LAST_TS_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_last_ts == $past(in_ts)); // R2

    AST_FRESH_FIRST_TS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pkt_cnt == PKT_W'(1)) |-> out_first_ts == out_last_ts); // R3

    AST_PKT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_pkt_cnt != '0); // R4

    AST_BYTES_COVER_LEN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_byte_cnt >= BYTE_W'($past(in_len))); // R5

endmodule

bind fru_updater fru_updater_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_key       (in_key),
    .in_ts        (in_ts),
    .in_len       (in_len),
    .out_valid    (out_valid),
    .out_key      (out_key),
    .out_first_ts (out_first_ts),
    .out_last_ts  (out_last_ts),
    .out_pkt_cnt  (out_pkt_cnt),
    .out_byte_cnt (out_byte_cnt)
);

// File: tb/fru_updater_test.sv
module fru_updater_test;
    import fru_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RD         = 2;
    localparam int WR         = 2;
    localparam int D          = RD + WR - 1;
    localparam int WDOG       = 60000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [KEY_W-1:0]  in_key = '0;
    logic [TS_W-1:0]   in_first_ts = '0;
    logic [TS_W-1:0]   in_last_ts = '0;
    logic [PKT_W-1:0]  in_pkt_cnt = '0;
    logic [BYTE_W-1:0] in_byte_cnt = '0;
    logic [TS_W-1:0]   in_ts = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic              out_valid;
    logic [KEY_W-1:0]  out_key;
    logic [TS_W-1:0]   out_first_ts;
    logic [TS_W-1:0]   out_last_ts;
    logic [PKT_W-1:0]  out_pkt_cnt;
    logic [BYTE_W-1:0] out_byte_cnt;

    fru_updater #(.RD_LAT(RD), .WR_LAT(WR)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key),
        .in_first_ts(in_first_ts), .in_last_ts(in_last_ts),
        .in_pkt_cnt(in_pkt_cnt), .in_byte_cnt(in_byte_cnt),
        .in_ts(in_ts), .in_len(in_len), .out_valid(out_valid),
        .out_key(out_key), .out_first_ts(out_first_ts),
        .out_last_ts(out_last_ts), .out_pkt_cnt(out_pkt_cnt),
        .out_byte_cnt(out_byte_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    // Bench history of its own expected results, index 0 newest
    logic             hv   [D];
    logic [KEY_W-1:0] hk   [D];
    flow_val_t        hval [D];
    logic             pend_v = 1'b0;
    flow_rec_t        pend_rec;
    string            pend_tag = "R1";

    localparam logic [KEY_W-1:0] K1 = 104'h11;
    localparam logic [KEY_W-1:0] K2 = 104'h22;
    localparam logic [KEY_W-1:0] K3 = 104'h33;
    localparam logic [KEY_W-1:0] K4 = 104'hABCD_0000_0000_0000_0000_0044;

    function automatic flow_val_t model_upd(flow_val_t b, logic [TS_W-1:0] ts,
                                            logic [LEN_W-1:0] len);
        flow_val_t    r;
        logic [BYTE_W:0] s;
        r.last_ts  = ts;
        r.first_ts = (b.pkt_cnt == 0) ? ts : b.first_ts;
        r.pkt_cnt  = (b.pkt_cnt == {PKT_W{1'b1}}) ? b.pkt_cnt : b.pkt_cnt + 1'b1;
        s = {1'b0, b.byte_cnt} + {{(BYTE_W+1-LEN_W){1'b0}}, len};
        r.byte_cnt = s[BYTE_W] ? {BYTE_W{1'b1}} : s[BYTE_W-1:0];
        return r;
    endfunction

    function automatic flow_val_t mkval(logic [TS_W-1:0] f, logic [TS_W-1:0] l,
                                        logic [PKT_W-1:0] p, logic [BYTE_W-1:0] b);
        flow_val_t v;
        v.first_ts = f; v.last_ts = l; v.pkt_cnt = p; v.byte_cnt = b;
        return v;
    endfunction

    task automatic clear_hist();
        for (int i = 0; i < D; i++) begin
            hv[i] = 1'b0; hk[i] = '0; hval[i] = '0;
        end
        pend_v = 1'b0;
    endtask

    task automatic check_pending();
        flow_rec_t act;
        act.key = out_key;
        act.val = mkval(out_first_ts, out_last_ts, out_pkt_cnt, out_byte_cnt);
        vectors++;
        if (pend_v) begin
            if (!out_valid || act !== pend_rec) begin
                miscompares++;
                $display("FAIL %s: act v=%0b key=%h f=%0d l=%0d p=%0d b=%0d exp v=1 key=%h f=%0d l=%0d p=%0d b=%0d",
                         pend_tag, out_valid, act.key, act.val.first_ts, act.val.last_ts,
                         act.val.pkt_cnt, act.val.byte_cnt, pend_rec.key,
                         pend_rec.val.first_ts, pend_rec.val.last_ts,
                         pend_rec.val.pkt_cnt, pend_rec.val.byte_cnt);
            end
        end else if (out_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL %s: out_valid act=%0b exp=0", pend_tag, out_valid);
        end
    endtask

    // One cycle: check the previous result, then drive this cycle's input.
    task automatic step(input logic v, input logic [KEY_W-1:0] key,
                        input flow_val_t tbl, input logic [TS_W-1:0] ts,
                        input logic [LEN_W-1:0] len, input string tag);
        flow_val_t base;
        flow_val_t exp_v;
        @(negedge clk);
        check_pending();
        in_valid = v; in_key = key; in_ts = ts; in_len = len;
        in_first_ts = tbl.first_ts; in_last_ts = tbl.last_ts;
        in_pkt_cnt = tbl.pkt_cnt; in_byte_cnt = tbl.byte_cnt;
        base = tbl;
        for (int i = D - 1; i >= 0; i--) begin
            if (hv[i] && hk[i] == key) base = hval[i];
        end
        exp_v = model_upd(base, ts, len);
        for (int i = D - 1; i > 0; i--) begin
            hv[i] = hv[i-1]; hk[i] = hk[i-1]; hval[i] = hval[i-1];
        end
        hv[0] = v; hk[0] = key; hval[0] = exp_v;
        pend_v = v;
        pend_rec.key = key;
        pend_rec.val = exp_v;
        pend_tag = v ? tag : "R1 idle";
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, "R1");
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_pending();
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_hist();
        pend_tag = "R9 reset";
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            miscompares++;
            $display("FAIL watchdog: act cycles=%0d exp <=%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    logic [TS_W-1:0] tnow = 64'd1000;
    localparam logic [PKT_W-1:0]  PMAX = {PKT_W{1'b1}};
    localparam logic [BYTE_W-1:0] BMAX = {BYTE_W{1'b1}};

    initial begin
        void'($urandom(32'd20240611));
        clear_hist();
        do_reset();
        step(1'b0, '0, '0, '0, '0, "R9 reset state");

        // R3 fresh flow, R2 last timestamp
        step(1'b1, K1, '0, 64'd100, 16'd64, "R3 fresh first ts");
        // R6 back-to-back forwarding, stale table copy ignored
        step(1'b1, K1, '0, 64'd110, 16'd100, "R6 back-to-back");
        // R6 edge: exactly D cycles after the last K1 result
        idle(D - 1);
        step(1'b1, K1, mkval(64'd1, 64'd2, 24'd9, 40'd9), 64'd120, 16'd10, "R6 window edge");
        // R7 one cycle beyond the window
        idle(D);
        step(1'b1, K1, mkval(64'd7, 64'd8, 24'd7, 40'd700), 64'd130, 16'd5, "R7 window expired");
        // R7 different key while K1 buffered; R3 non-zero keeps first ts
        step(1'b1, K2, mkval(64'd50, 64'd60, 24'd5, 40'd500), 64'd140, 16'd20, "R7 other key");
        // R8 newest-first among repeated keys
        step(1'b1, K3, '0, 64'd150, 16'd1, "R8 first");
        step(1'b1, K3, '0, 64'd151, 16'd2, "R8 second");
        step(1'b1, K3, '0, 64'd152, 16'd3, "R8 newest of two");
        step(1'b1, K2, '0, 64'd153, 16'd4, "R8 skip K3");
        step(1'b1, K3, '0, 64'd154, 16'd5, "R8 newest over older");
        idle(D);
        // R4 saturation and the step reaching the limit
        step(1'b1, K4, mkval(64'd3, 64'd4, PMAX, 40'd0), 64'd160, 16'd1, "R4 counter held at max");
        idle(D);
        step(1'b1, K4, mkval(64'd3, 64'd4, PMAX - 1'b1, 40'd0), 64'd161, 16'd1, "R4 counter reaches max");
        idle(D);
        // R5 byte clamp and exact-fit sum
        step(1'b1, K4, mkval(64'd3, 64'd4, 24'd2, BMAX - 40'd10), 64'd162, 16'd100, "R5 bytes clamp");
        idle(D);
        step(1'b1, K4, mkval(64'd3, 64'd4, 24'd2, BMAX - 40'd100), 64'd163, 16'd100, "R5 bytes exact max");
        // R9 reset empties the buffer
        step(1'b1, K2, '0, 64'd170, 16'd8, "R9 before reset");
        step(1'b1, '0, '0, 64'd171, 16'd8, "R9 before reset zero key");
        do_reset();
        step(1'b1, K2, mkval(64'd20, 64'd21, 24'd4, 40'd40), 64'd180, 16'd8, "R9 no forward after reset");
        step(1'b1, '0, mkval(64'd30, 64'd31, 24'd3, 40'd30), 64'd181, 16'd8, "R9 empty slot vs zero key");
        idle(D);

        // Random traffic over a small key pool
        for (int n = 0; n < 4000; n++) begin
            logic              v;
            logic [KEY_W-1:0]  k;
            logic [PKT_W-1:0]  p;
            logic [BYTE_W-1:0] b;
            logic [31:0]       r;
            v = ($urandom_range(3) != 0);
            case ($urandom_range(3))
                0: k = K1;
                1: k = K2;
                2: k = K3;
                default: k = K4;
            endcase
            r = $urandom;
            p = (r[3:0] == 0) ? PMAX - PKT_W'(r[5:4]) : PKT_W'(r[7:6]);
            b = (r[11:8] == 0) ? BMAX - BYTE_W'(r[27:12]) : BYTE_W'(r[27:12]);
            tnow = tnow + 64'($urandom_range(1, 5));
            step(v, k, mkval(tnow - 64'd900, tnow - 64'd10, p, b), tnow,
                 LEN_W'($urandom), "R6 random");
        end
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule